// File: doc/BRIEF.md
# Machine Control-Register Unit with Cycle Counter

This block carries out the six control-register instructions of a small 32-bit core. Each one reads a control register, combines its old value with an operand, and writes the result back. Three operations are supported: plain write, bit set and bit clear. Each comes in a register-operand form and an immediate form. In the immediate form the operand is the 5-bit source-index field, zero-extended. The unit holds two pieces of state: a general scratch register and a free-running 32-bit cycle counter. The counter advances once per instruction step.

The core presents one access per cycle with `csrEn`. The read result, a read-valid flag and an illegal-address flag come back on the next clock edge. The read result is always the value the register had before the access. The rules on register indices decide whether an access reads, writes, or does both. A plain write whose destination index is zero does not read. A set or clear whose operand is zero does not write. This lets the core use a single instruction as a pure read or a pure write without side effects.

Three addresses select the counter: 0xB00, 0xB01 and 0xB02. All three read the same counter. Only 0xB00 accepts writes to it.

Top module: `mcsr_unit`

## Requirements
- R1: The scratch register is at address 0x340. After a write, a later read returns the written value. After reset it reads 0.
- R2: Operation code 1 (set) writes old OR operand. Operation code 2 (clear) writes old AND NOT operand. Operation code 0 writes the operand.
- R3: Addresses 0xB00, 0xB01 and 0xB02 all return the same 32-bit counter value.
- R4: Writes to 0xB01 and 0xB02 leave the counter unchanged and are not flagged illegal. Only 0xB00 writes the counter.
- R5: A write (code 0) with destination index 0 performs no read: `rdValid` is 0 and `rdData` is 0. The write still takes place.
- R6: A set or clear performs no write when the operand is zero. The operand is `srcVal` when `useImm`=0 and `srcIdx` when `useImm`=1. Such an access still reads.
- R7: The counter increases by one on every cycle in which `stepEn` is 1. It holds otherwise. It reads 0 after reset.
- R8: A counter write and a step in the same cycle load the written value with no increment.
- R9: An access to any other address gives `illegalAddr`=1 and `rdValid`=0 for exactly one cycle, and it changes no state.
- R10: The read result is the register value before the access, returned one cycle after `csrEn`.
- R11: In the immediate form the operand is `srcIdx` zero-extended to 32 bits. `srcVal` is ignored.
- R12: Operation code 3 has no effect: no read, no write, no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | One instruction step completed; advances the counter |
| csrEn | input | 1 | Control-register access this cycle |
| csrAddr | input | 12 | Register address |
| csrOp | input | 2 | 0 write, 1 set, 2 clear, 3 no operation |
| useImm | input | 1 | 1 selects the immediate form |
| srcVal | input | 32 | Source register value |
| srcIdx | input | 5 | Source register index, or the immediate |
| dstIdx | input | 5 | Destination register index |
| rdData | output | 32 | Old register value, or 0 when no valid read |
| rdValid | output | 1 | Read performed on an implemented address |
| illegalAddr | output | 1 | Access to an unimplemented address |

## Verification
The assertions check the following on every cycle:
- The counter steps by exactly one, or holds, whenever no counter write is decoded.
- The scratch register holds when it is not written.
- An illegal-address result never comes with valid read data.
- An idle or no-operation cycle leaves both flags low.
- The decoder never targets both registers at once.

Other behaviour depends on sequences of accesses, so only the bench scenarios can show it. These cover read-before-write data, the set and clear arithmetic, aliasing across the three counter addresses, ignored writes to the read-only aliases, and the suppression rules for a zero destination index and a zero operand, checked through a later read.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  parameter int XLEN   = 32;
  parameter int ADDR_W = 12;
  parameter int IDX_W  = 5;

  parameter logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h340;
  parameter logic [ADDR_W-1:0] ADDR_CNT_RW  = 12'hB00;
  parameter logic [ADDR_W-1:0] ADDR_CNT_A1  = 12'hB01;
  parameter logic [ADDR_W-1:0] ADDR_CNT_A2  = 12'hB02;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic    rdEn;
    logic    selCount;
    logic    wrScratch;
    logic    wrCount;
    logic    illegal;
    csr_op_e op;
  } csr_strobe_t;
endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [1:0]        csrOp,
  input  logic              useImm,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  output csr_strobe_t       strb
);
  logic isScratch, isCount, isImpl, opOk, operandZero, wrEn;
  csr_op_e opDec;

  always_comb begin
    opDec       = csr_op_e'(csrOp);
    isScratch   = (csrAddr == ADDR_SCRATCH);
    isCount     = (csrAddr == ADDR_CNT_RW) || (csrAddr == ADDR_CNT_A1) ||
                  (csrAddr == ADDR_CNT_A2);
    isImpl      = isScratch || isCount;
    opOk        = csrEn && (opDec != OP_NONE);
    operandZero = useImm ? (srcIdx == '0) : (srcVal == '0);
    // a write is always performed; set/clear only with a nonzero operand
    wrEn        = opOk && ((opDec == OP_WRITE) || !operandZero);

    strb.op        = opDec;
    strb.selCount  = isCount;
    strb.rdEn      = opOk && isImpl && !((opDec == OP_WRITE) && (dstIdx == '0));
    strb.wrScratch = wrEn && isScratch;
    strb.wrCount   = wrEn && (csrAddr == ADDR_CNT_RW);
    strb.illegal   = opOk && !isImpl;
  end

  // R4: at most one register is targeted by a decoded write
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrScratch, strb.wrCount}));
endmodule

// File: rtl/mcsr_dp.sv
module mcsr_dp
  import mcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic             useImm,
  input  logic [XLEN-1:0]  srcVal,
  input  logic [IDX_W-1:0] srcIdx,
  input  csr_strobe_t      strb,
  output logic [XLEN-1:0]  rdData,
  output logic             rdValid,
  output logic             illegalAddr
);
  logic [XLEN-1:0] scratchQ, countQ;
  logic [XLEN-1:0] operand, oldVal, newVal;

  always_comb begin
    operand = useImm ? XLEN'(srcIdx) : srcVal;
    oldVal  = strb.selCount ? countQ : scratchQ;
    unique case (strb.op)
      OP_SET:   newVal = oldVal | operand;
      OP_CLEAR: newVal = oldVal & ~operand;
      default:  newVal = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchQ    <= '0;
      countQ      <= '0;
      rdData      <= '0;
      rdValid     <= 1'b0;
      illegalAddr <= 1'b0;
    end else begin
      if (strb.wrScratch) scratchQ <= newVal;
      if (strb.wrCount)   countQ <= newVal;      // explicit write beats the step
      else if (stepEn)    countQ <= countQ + 1'b1;
      rdData      <= strb.rdEn ? oldVal : '0;
      rdValid     <= strb.rdEn;
      illegalAddr <= strb.illegal;
    end
  end

  // R7: counter steps by one or holds when no write is decoded
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCount && stepEn) |=> (countQ == $past(countQ) + 1'b1));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrCount && !stepEn) |=> $stable(countQ));
  // R6: scratch changes only on a decoded write
  p_scratch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrScratch |=> $stable(scratchQ));
  // R9: illegal result never carries read data
  p_illegal_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegalAddr |-> (!rdValid && rdData == '0));
  // R12: no decoded read or fault gives quiet flags next cycle
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdEn && !strb.illegal) |=> (!rdValid && !illegalAddr));
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              csrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [1:0]        csrOp,
  input  logic              useImm,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic [XLEN-1:0]   rdData,
  output logic              rdValid,
  output logic              illegalAddr
);
  csr_strobe_t strb;

  mcsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csrEn(csrEn), .csrAddr(csrAddr), .csrOp(csrOp),
    .useImm(useImm), .srcVal(srcVal), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .strb(strb)
  );

  mcsr_dp u_dp (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .useImm(useImm), .srcVal(srcVal),
    .srcIdx(srcIdx), .strb(strb), .rdData(rdData), .rdValid(rdValid),
    .illegalAddr(illegalAddr)
  );
endmodule

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0, csrEn = 1'b0, useImm = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  csrOp = '0;
  logic [31:0] srcVal = '0;
  logic [4:0]  srcIdx = '0, dstIdx = '0;
  logic [31:0] rdData;
  logic        rdValid, illegalAddr;

  always #2.5 clk = ~clk;

  mcsr_unit u0 (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .csrEn(csrEn), .csrAddr(csrAddr),
    .csrOp(csrOp), .useImm(useImm), .srcVal(srcVal), .srcIdx(srcIdx),
    .dstIdx(dstIdx), .rdData(rdData), .rdValid(rdValid), .illegalAddr(illegalAddr)
  );

  typedef struct {
    int          cyc;
    logic [31:0] data;
    logic        valid;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0, cycNow = 0;
  logic [31:0] refScr = '0, refCnt = '0;

  // reference state from the requirements, updated with the inputs seen at the edge
  always @(posedge clk) begin
    cycNow <= cycNow + 1;
    if (!rstN) begin
      refScr <= '0; refCnt <= '0;
    end else begin
      logic [31:0] opnd, old, nv;
      logic wr;
      opnd = useImm ? {27'd0, srcIdx} : srcVal;
      wr = csrEn && csrOp != 2'd3 && (csrOp == 2'd0 || opnd != 0);
      old = (csrAddr == 12'h340) ? refScr : refCnt;
      nv = (csrOp == 2'd1) ? (old | opnd) : (csrOp == 2'd2) ? (old & ~opnd) : opnd;
      if (wr && csrAddr == 12'h340) refScr <= nv;
      if (wr && csrAddr == 12'hB00) refCnt <= nv;
      else if (stepEn) refCnt <= refCnt + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops items issued on an earlier cycle and compares
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].cyc < cycNow) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, {rdData, 6'd0, rdValid, illegalAddr}, {e.data, 6'd0, e.valid, e.ill});
    end
  end

  // driver: called at a falling edge, drives one access and records the expectation
  task automatic access(string tag, logic [11:0] a, logic [1:0] op, logic imm,
                        logic [31:0] sv, logic [4:0] si, logic [4:0] di, logic st);
    exp_t e;
    logic isS, isC, rd;
    isS = (a == 12'h340);
    isC = (a == 12'hB00 || a == 12'hB01 || a == 12'hB02);
    rd  = op != 2'd3 && (isS || isC) && !(op == 2'd0 && di == 0);
    e.cyc = cycNow; e.tag = tag; e.valid = rd;
    e.ill = op != 2'd3 && !(isS || isC);
    e.data = rd ? (isS ? refScr : refCnt) : 32'd0;
    expQ.push_back(e);
    csrEn = 1'b1; csrAddr = a; csrOp = op; useImm = imm;
    srcVal = sv; srcIdx = si; dstIdx = di; stepEn = st;
    @(negedge clk);
    csrEn = 1'b0; stepEn = 1'b0; csrOp = 2'd0;
  endtask

  task automatic idle(int n, logic st);
    stepEn = st;
    repeat (n) @(negedge clk);
    stepEn = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R7 reset outputs", {rdData, 6'd0, rdValid, illegalAddr}, 32'd0);
    access("R1 scratch reads 0 after reset", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd1, 1'b0);
    access("R7 counter reads 0 after reset", 12'hB00, 2'd2, 1'b1, 0, 5'd0, 5'd2, 1'b0);
    // R1, R10: write then read back old/new
    access("R10 write returns old scratch", 12'h340, 2'd0, 1'b0, 32'hA5A5_0F0F, 5'd3, 5'd4, 1'b0);
    access("R1 scratch holds written value", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd4, 1'b0);
    // R2 set and clear
    access("R2 set returns old", 12'h340, 2'd1, 1'b0, 32'h0000_F0F0, 5'd5, 5'd6, 1'b0);
    access("R2 clear returns set result A5A5FFFF", 12'h340, 2'd2, 1'b0, 32'hFF00_0000, 5'd5, 5'd6, 1'b0);
    access("R2 clear result 00A5FFFF", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd6, 1'b0);
    check("R2 model scratch", refScr, 32'h00A5_FFFF);
    // R6 zero operand skips write; immediate zero with nonzero srcVal
    access("R6 clear with zero reg", 12'h340, 2'd2, 1'b0, 32'd0, 5'd9, 5'd7, 1'b0);
    access("R6 imm clear idx0 ignores srcVal", 12'h340, 2'd2, 1'b1, 32'hFFFF_FFFF, 5'd0, 5'd7, 1'b0);
    access("R6 scratch unchanged", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd7, 1'b0);
    // R11 immediate zero-extension, srcVal ignored
    access("R11 imm write", 12'h340, 2'd0, 1'b1, 32'hDEAD_BEEF, 5'd31, 5'd8, 1'b0);
    access("R11 reads 0000001F", 12'h340, 2'd1, 1'b1, 0, 5'd0, 5'd8, 1'b0);
    check("R11 model scratch", refScr, 32'h0000_001F);
    // R5 write with dst 0: no read, write happens
    access("R5 no read when dst 0", 12'h340, 2'd0, 1'b0, 32'h1234_5678, 5'd1, 5'd0, 1'b0);
    access("R5 write still performed", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd1, 1'b0);
    // R7 counting, R3 aliasing
    idle(5, 1'b1);
    access("R7 counter after 5 steps", 12'hB00, 2'd1, 1'b0, 0, 5'd0, 5'd1, 1'b0);
    access("R3 alias B01", 12'hB01, 2'd1, 1'b0, 0, 5'd0, 5'd1, 1'b0);
    access("R3 alias B02", 12'hB02, 2'd2, 1'b1, 0, 5'd0, 5'd1, 1'b0);
    check("R7 model counter", refCnt, 32'd5);
    // R4 writes to aliases ignored
    access("R4 write B01", 12'hB01, 2'd0, 1'b0, 32'h7777_0000, 5'd1, 5'd2, 1'b0);
    access("R4 write B02", 12'hB02, 2'd1, 1'b0, 32'h00FF_0000, 5'd1, 5'd2, 1'b0);
    access("R4 counter unchanged", 12'hB00, 2'd1, 1'b0, 0, 5'd0, 5'd2, 1'b0);
    // R8 write priority over step
    access("R8 write with step", 12'hB00, 2'd0, 1'b0, 32'd100, 5'd1, 5'd2, 1'b1);
    access("R8 counter is 100", 12'hB00, 2'd1, 1'b0, 0, 5'd0, 5'd2, 1'b1);
    access("R7 counter is 101", 12'hB02, 2'd1, 1'b0, 0, 5'd0, 5'd2, 1'b0);
    access("R8 set on counter with step", 12'hB00, 2'd1, 1'b0, 32'hF000_0000, 5'd3, 5'd2, 1'b1);
    access("R8 counter is F0000065", 12'hB00, 2'd1, 1'b0, 0, 5'd0, 5'd2, 1'b0);
    check("R8 model counter", refCnt, 32'hF000_0065);
    // R9 illegal address
    access("R9 illegal read", 12'h341, 2'd1, 1'b0, 0, 5'd0, 5'd3, 1'b0);
    access("R9 illegal write", 12'hB03, 2'd0, 1'b0, 32'h5, 5'd3, 5'd3, 1'b0);
    access("R9 flag one cycle, scratch intact", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd3, 1'b0);
    // R12 op 3 no effect
    access("R12 op3 no flags", 12'h340, 2'd3, 1'b0, 32'hFFFF_FFFF, 5'd1, 5'd3, 1'b0);
    access("R12 op3 illegal addr quiet", 12'h7FF, 2'd3, 1'b0, 0, 5'd0, 5'd3, 1'b0);
    access("R12 scratch unchanged", 12'h340, 2'd1, 1'b0, 0, 5'd0, 5'd3, 1'b0);
    check("R12 model scratch", refScr, 32'h1234_5678);
    idle(3, 1'b0);
    check("R10 queue drained", expQ.size(), 0);
    finish_run();
  end
endmodule